// File: doc/BRIEF.md
# Two-Lane SIMD Exception Flag Register

This block keeps the exception status word of a two-lane (high and low element) SIMD unit that runs both floating-point and integer operations. On every cycle with a valid instruction it takes the per-lane event bits that the execution unit already produced, together with the data-exception-taken indications and the two trap enables. From these it rewrites the per-lane flags of the lanes that the instruction touched and ORs the events into a set of sticky summary flags. Operand classification, arithmetic and trap generation stay in the execution unit; this block only records their outcome.

Software reads the whole status word from `rdata_o` and can overwrite it with a single write strobe. The summary flags stay set until such a write clears them. The per-lane flags describe only the most recent instruction of their kind.

Top module: `simd_fp_flags`

## Requirements
- R1: While `rst_ni` is low the status word reads 0x00000000, and it stays there until the first update after release.
- R2: Word layout, by bit index: 31 integer overflow summary, 30 high integer overflow, 29 high guard, 28 high sticky, 27 high invalid, 26 high divide-by-zero, 25 high underflow, 24 high overflow, 21 inexact summary, 20 invalid summary, 19 divide-by-zero summary, 18 underflow summary, 17 overflow summary, 15 low integer overflow, 14 low guard, 13 low sticky, 12 low invalid, 11 low divide-by-zero, 10 low underflow, 9 low overflow. Bits 23, 22, 16 and 8..0 always read 0, and a write cannot set them (writable mask 0xFF3EFE00).
- R3: With `wr_en_i` high, the word becomes `wr_data_i & 0xFF3EFE00` after the edge, whatever instruction update happens in the same cycle.
- R4: With neither `valid_i` nor `wr_en_i` high, the word does not change.
- R5: Event inputs per lane are encoded as bit 0 overflow, 1 underflow, 2 divide-by-zero, 3 invalid, 4 inexact, 5 guard, 6 sticky, 7 integer overflow. A valid vector floating-point instruction (`is_int_i`=0, `is_scalar_i`=0) replaces the overflow, underflow, divide-by-zero, invalid, guard and sticky flags of both lanes with that lane's event bits.
- R6: A lane's guard and sticky flags are written as zero when its data-exception input is high for that floating-point instruction.
- R7: A valid scalar floating-point instruction writes all six high-lane floating-point flags to zero and ignores the high-lane events and data exception. The low lane is updated as in R5 and R6.
- R8: A valid integer instruction (`is_int_i`=1, scalar or vector) replaces both integer overflow flags with event bit 7 of each lane and leaves every floating-point flag unchanged. The integer overflow summary sets when the high flag is written as one.
- R9: The invalid, divide-by-zero, underflow and overflow summaries set when the matching flag of either active lane is written as one, and they hold until a software write.
- R10: The inexact summary sets on an inexact event in either active lane when no active lane reports a data exception.
- R11: The inexact summary also sets on an overflow in either active lane while `ovf_en_i` is 0, and on an underflow in either active lane while `unf_en_i` is 0 and no active lane reports a data exception. It holds until a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction result valid this cycle |
| is_int_i | input | 1 | 1 for integer/fractional instruction, 0 for floating-point |
| is_scalar_i | input | 1 | 1 for scalar instruction (low lane only) |
| hi_ev_i | input | 8 | High-lane event bits (encoding in R5) |
| lo_ev_i | input | 8 | Low-lane event bits (encoding in R5) |
| hi_dexc_i | input | 1 | Data exception taken for the high lane |
| lo_dexc_i | input | 1 | Data exception taken for the low lane |
| ovf_en_i | input | 1 | Overflow exception enable |
| unf_en_i | input | 1 | Underflow exception enable |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| rdata_o | output | 32 | Current status word |

## Verification
The properties assume that the event inputs are only meaningful while `valid_i` is high and that the enables and data-exception bits are stable inputs sampled at the same edge. They do not assume that events are mutually exclusive, so any combination of event bits is legal. The stimulus drives every input away from the clock edge and holds it for one full cycle. It mixes a hand-built sequence that reaches each lane, scalar, integer and masking case with random vectors, random enable settings and writes interleaved at random, and it never leaves an input undriven.

// File: rtl/simd_fp_flags_pkg.sv
package simd_fp_flags_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = 2;
  localparam int unsigned EV_W   = 8;
  localparam int unsigned LO     = 0;
  localparam int unsigned HI     = LANES - 1;

  // bit positions in the status word
  localparam int unsigned B_SOVH  = 31;
  localparam int unsigned B_IOV_H = 30;
  localparam int unsigned B_FP_H  = 24; // six flags at 29..24
  localparam int unsigned B_SUM   = 17; // five flags at 21..17
  localparam int unsigned B_IOV_L = 15;
  localparam int unsigned B_FP_L  = 9;  // six flags at 14..9
  localparam logic [WORD_W-1:0] WR_MASK = 32'hFF3E_FE00;

  typedef struct packed {
    logic int_ov;
    logic sticky;
    logic guard;
    logic inx;
    logic inv;
    logic dbz;
    logic unf;
    logic ovf;
  } lane_ev_t;

  typedef struct packed {
    logic guard;
    logic sticky;
    logic inv;
    logic dbz;
    logic unf;
    logic ovf;
  } lane_fp_t;

  typedef struct packed {
    logic inx;
    logic inv;
    logic dbz;
    logic unf;
    logic ovf;
  } sum_t;

  typedef struct packed {
    logic     sovh;
    logic     iov_hi;
    logic     iov_lo;
    lane_fp_t fp_hi;
    lane_fp_t fp_lo;
    sum_t     sum;
  } state_t;

  function automatic logic [WORD_W-1:0] pack_word(input state_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_SOVH]            = s.sovh;
    w[B_IOV_H]           = s.iov_hi;
    w[B_FP_H +: 6]       = s.fp_hi;
    w[B_SUM +: 5]        = s.sum;
    w[B_IOV_L]           = s.iov_lo;
    w[B_FP_L +: 6]       = s.fp_lo;
    return w;
  endfunction

  function automatic state_t unpack_word(input logic [WORD_W-1:0] w);
    state_t s;
    s.sovh   = w[B_SOVH];
    s.iov_hi = w[B_IOV_H];
    s.fp_hi  = w[B_FP_H +: 6];
    s.sum    = w[B_SUM +: 5];
    s.iov_lo = w[B_IOV_L];
    s.fp_lo  = w[B_FP_L +: 6];
    return s;
  endfunction

endpackage

// File: rtl/simd_fp_flags_lane.sv
module simd_fp_flags_lane
  import simd_fp_flags_pkg::*;
#(
  parameter bit HIGH_LANE = 1'b0
) (
  input  logic     valid_i,
  input  logic     is_int_i,
  input  logic     is_scalar_i,
  input  logic     dexc_i,
  input  lane_ev_t ev_i,
  input  lane_fp_t fp_q_i,
  input  logic     iov_q_i,
  output lane_fp_t fp_d_o,
  output logic     iov_d_o,
  output lane_ev_t ev_eff_o,
  output logic     dexc_eff_o
);

  logic fp_op, int_op, lane_on;

  assign fp_op   = valid_i & ~is_int_i;
  assign int_op  = valid_i & is_int_i;
  // scalar fp work runs in the low lane only
  assign lane_on = ~(HIGH_LANE & is_scalar_i);

  always_comb begin
    ev_eff_o   = '0;
    dexc_eff_o = 1'b0;
    if (fp_op && lane_on) begin
      ev_eff_o        = ev_i;
      ev_eff_o.int_ov = 1'b0;
      dexc_eff_o      = dexc_i;
    end else if (int_op) begin
      ev_eff_o.int_ov = ev_i.int_ov;
    end
  end

  always_comb begin
    fp_d_o = fp_q_i;
    if (fp_op) begin
      fp_d_o.ovf    = ev_eff_o.ovf;
      fp_d_o.unf    = ev_eff_o.unf;
      fp_d_o.dbz    = ev_eff_o.dbz;
      fp_d_o.inv    = ev_eff_o.inv;
      fp_d_o.guard  = ev_eff_o.guard  & ~dexc_eff_o;
      fp_d_o.sticky = ev_eff_o.sticky & ~dexc_eff_o;
    end
  end

  assign iov_d_o = int_op ? ev_eff_o.int_ov : iov_q_i;

endmodule

// File: rtl/simd_fp_flags_sum.sv
module simd_fp_flags_sum
  import simd_fp_flags_pkg::*;
(
  input  lane_ev_t ev_hi_i,
  input  lane_ev_t ev_lo_i,
  input  logic     dexc_hi_i,
  input  logic     dexc_lo_i,
  input  logic     ovf_en_i,
  input  logic     unf_en_i,
  output sum_t     set_o,
  output logic     sovh_set_o
);

  logic any_dexc, any_ovf, any_unf, any_inx;

  assign any_dexc = dexc_hi_i | dexc_lo_i;
  assign any_ovf  = ev_hi_i.ovf | ev_lo_i.ovf;
  assign any_unf  = ev_hi_i.unf | ev_lo_i.unf;
  assign any_inx  = ev_hi_i.inx | ev_lo_i.inx;

  always_comb begin
    set_o.ovf = any_ovf;
    set_o.unf = any_unf;
    set_o.dbz = ev_hi_i.dbz | ev_lo_i.dbz;
    set_o.inv = ev_hi_i.inv | ev_lo_i.inv;
    // masked overflow is not gated by data exceptions; masked underflow is
    set_o.inx = (any_inx & ~any_dexc)
              | (any_ovf & ~ovf_en_i)
              | (any_unf & ~unf_en_i & ~any_dexc);
  end

  assign sovh_set_o = ev_hi_i.int_ov;

endmodule

// File: rtl/simd_fp_flags.sv
module simd_fp_flags
  import simd_fp_flags_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              is_int_i,
  input  logic              is_scalar_i,
  input  logic [EV_W-1:0]   hi_ev_i,
  input  logic [EV_W-1:0]   lo_ev_i,
  input  logic              hi_dexc_i,
  input  logic              lo_dexc_i,
  input  logic              ovf_en_i,
  input  logic              unf_en_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rdata_o
);

  state_t   st_q, st_d;
  lane_ev_t ev_in   [LANES];
  lane_ev_t ev_eff  [LANES];
  lane_fp_t fp_cur  [LANES];
  lane_fp_t fp_nxt  [LANES];
  logic     iov_cur [LANES];
  logic     iov_nxt [LANES];
  logic     dx_in   [LANES];
  logic     dx_eff  [LANES];
  sum_t     sum_set;
  logic     sovh_set;

  assign ev_in[LO]   = lane_ev_t'(lo_ev_i);
  assign ev_in[HI]   = lane_ev_t'(hi_ev_i);
  assign dx_in[LO]   = lo_dexc_i;
  assign dx_in[HI]   = hi_dexc_i;
  assign fp_cur[LO]  = st_q.fp_lo;
  assign fp_cur[HI]  = st_q.fp_hi;
  assign iov_cur[LO] = st_q.iov_lo;
  assign iov_cur[HI] = st_q.iov_hi;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_fp_flags_lane #(
      .HIGH_LANE (g == HI)
    ) u_lane (
      .valid_i     (valid_i),
      .is_int_i    (is_int_i),
      .is_scalar_i (is_scalar_i),
      .dexc_i      (dx_in[g]),
      .ev_i        (ev_in[g]),
      .fp_q_i      (fp_cur[g]),
      .iov_q_i     (iov_cur[g]),
      .fp_d_o      (fp_nxt[g]),
      .iov_d_o     (iov_nxt[g]),
      .ev_eff_o    (ev_eff[g]),
      .dexc_eff_o  (dx_eff[g])
    );
  end

  simd_fp_flags_sum u_sum (
    .ev_hi_i    (ev_eff[HI]),
    .ev_lo_i    (ev_eff[LO]),
    .dexc_hi_i  (dx_eff[HI]),
    .dexc_lo_i  (dx_eff[LO]),
    .ovf_en_i   (ovf_en_i),
    .unf_en_i   (unf_en_i),
    .set_o      (sum_set),
    .sovh_set_o (sovh_set)
  );

  always_comb begin
    st_d = st_q;
    if (wr_en_i) begin
      st_d = unpack_word(wr_data_i);
    end else begin
      st_d.fp_hi  = fp_nxt[HI];
      st_d.fp_lo  = fp_nxt[LO];
      st_d.iov_hi = iov_nxt[HI];
      st_d.iov_lo = iov_nxt[LO];
      st_d.sum    = st_q.sum | sum_set;
      st_d.sovh   = st_q.sovh | sovh_set;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign rdata_o = pack_word(st_q);

endmodule

// File: rtl/simd_fp_flags_chk.sv
module simd_fp_flags_chk
  import simd_fp_flags_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              is_int_i,
  input logic              is_scalar_i,
  input logic [EV_W-1:0]   hi_ev_i,
  input logic [EV_W-1:0]   lo_ev_i,
  input logic              lo_dexc_i,
  input logic              ovf_en_i,
  input logic              wr_en_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic [WORD_W-1:0] rdata_o
);

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~WR_MASK) == '0);

  assert_write_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rdata_o == ($past(wr_data_i) & WR_MASK));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !wr_en_i) |=> $stable(rdata_o));

  assert_dexc_guard_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_int_i && lo_dexc_i && !wr_en_i) |=> (rdata_o[14:13] == 2'b00));

  assert_scalar_hi_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_int_i && is_scalar_i && !wr_en_i) |=> (rdata_o[29:24] == 6'b0));

  assert_int_keeps_fp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_int_i && !wr_en_i) |=>
      (rdata_o[29:24] == $past(rdata_o[29:24])) && (rdata_o[14:9] == $past(rdata_o[14:9])));

  assert_sovh_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_int_i && hi_ev_i[7] && !wr_en_i) |=> rdata_o[31]);

  assert_sum_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((rdata_o[21:17] & $past(rdata_o[21:17])) == $past(rdata_o[21:17])));

  assert_dbz_sum_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_int_i && lo_ev_i[2] && !wr_en_i) |=> (rdata_o[11] && rdata_o[19]));

  assert_masked_ovf_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_int_i && !is_scalar_i && hi_ev_i[0] && !ovf_en_i && !wr_en_i)
      |=> rdata_o[21]);

endmodule

bind simd_fp_flags simd_fp_flags_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .is_int_i    (is_int_i),
  .is_scalar_i (is_scalar_i),
  .hi_ev_i     (hi_ev_i),
  .lo_ev_i     (lo_ev_i),
  .lo_dexc_i   (lo_dexc_i),
  .ovf_en_i    (ovf_en_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rdata_o     (rdata_o)
);

// File: tb/simd_fp_flags_tb.sv
module simd_fp_flags_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] MASK = 32'hFF3E_FE00;
  localparam int unsigned WATCHDOG_CYC = 20000;
  localparam int unsigned N_RAND = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid, is_int, is_scalar, hdx, ldx, oen, uen, wr;
  logic [7:0]  hev, lev;
  logic [31:0] wdata, rdata;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  int unsigned cyc = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  simd_fp_flags dut_i (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .is_int_i (is_int),
    .is_scalar_i (is_scalar), .hi_ev_i (hev), .lo_ev_i (lev),
    .hi_dexc_i (hdx), .lo_dexc_i (ldx), .ovf_en_i (oen), .unf_en_i (uen),
    .wr_en_i (wr), .wr_data_i (wdata), .rdata_o (rdata)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        v, i, s;
    logic [7:0]  he, le;
    logic        hx, lx, oe, ue, w;
    logic [31:0] wd, exp;
  } vec_t;

  // event bits: 0 ovf 1 unf 2 dbz 3 inv 4 inx 5 guard 6 sticky 7 int_ov
  localparam vec_t VECS [13] = '{
    '{4'd5,  1'b1,1'b0,1'b0, 8'h01,8'h00, 1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0,        32'h0102_0000}, // R5 R9
    '{4'd5,  1'b1,1'b0,1'b0, 8'h00,8'h24, 1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0,        32'h000A_4800}, // R5 R9
    '{4'd7,  1'b1,1'b0,1'b1, 8'h3F,8'h10, 1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0,        32'h002A_0000}, // R7 R10
    '{4'd8,  1'b1,1'b1,1'b0, 8'h80,8'h80, 1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0,        32'hC02A_8000}, // R8
    '{4'd2,  1'b1,1'b0,1'b0, 8'h01,8'h00, 1'b0,1'b0,1'b1,1'b1,1'b1, 32'hFFFF_FFFF,32'hFF3E_FE00}, // R2 R3
    '{4'd3,  1'b0,1'b0,1'b0, 8'h00,8'h00, 1'b0,1'b0,1'b1,1'b1,1'b1, 32'h0,        32'h0000_0000}, // R3
    '{4'd6,  1'b1,1'b0,1'b0, 8'h62,8'h28, 1'b1,1'b0,1'b1,1'b0,1'b0, 32'h0,        32'h0214_5000}, // R6 R11
    '{4'd11, 1'b1,1'b0,1'b0, 8'h01,8'h00, 1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0,        32'h0136_0000}, // R11
    '{4'd4,  1'b0,1'b0,1'b0, 8'hFF,8'hFF, 1'b1,1'b1,1'b0,1'b0,1'b0, 32'h0,        32'h0136_0000}, // R4
    '{4'd8,  1'b1,1'b1,1'b1, 8'h00,8'h80, 1'b0,1'b0,1'b1,1'b1,1'b0, 32'h0,        32'h0136_8000}, // R8
    '{4'd3,  1'b0,1'b0,1'b0, 8'h00,8'h00, 1'b0,1'b0,1'b1,1'b1,1'b1, 32'h0,        32'h0000_0000}, // R3
    '{4'd10, 1'b1,1'b0,1'b0, 8'h10,8'h00, 1'b0,1'b1,1'b1,1'b1,1'b0, 32'h0,        32'h0000_0000}, // R10
    '{4'd11, 1'b1,1'b0,1'b0, 8'h00,8'h02, 1'b0,1'b0,1'b1,1'b0,1'b0, 32'h0,        32'h0024_0400}  // R11
  };

  function automatic logic [31:0] model(input logic [31:0] cur, input vec_t x);
    logic [31:0] r;
    logic [7:0]  h;
    logic        hxe, anyx;
    if (x.w) return x.wd & MASK;
    if (!x.v) return cur;
    r = cur;
    if (x.i) begin
      r[30] = x.he[7];
      r[15] = x.le[7];
      if (x.he[7]) r[31] = 1'b1;
    end else begin
      h   = x.s ? 8'h00 : x.he;
      hxe = x.s ? 1'b0 : x.hx;
      r[24] = h[0];  r[25] = h[1];  r[26] = h[2];  r[27] = h[3];
      r[29] = h[5] & ~hxe;  r[28] = h[6] & ~hxe;
      r[9]  = x.le[0]; r[10] = x.le[1]; r[11] = x.le[2]; r[12] = x.le[3];
      r[14] = x.le[5] & ~x.lx;  r[13] = x.le[6] & ~x.lx;
      if (h[0] | x.le[0]) r[17] = 1'b1;
      if (h[1] | x.le[1]) r[18] = 1'b1;
      if (h[2] | x.le[2]) r[19] = 1'b1;
      if (h[3] | x.le[3]) r[20] = 1'b1;
      anyx = hxe | x.lx;
      if (((h[4] | x.le[4]) & ~anyx) | ((h[0] | x.le[0]) & ~x.oe) |
          ((h[1] | x.le[1]) & ~x.ue & ~anyx)) r[21] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t x);
    @(negedge clk);
    valid = x.v; is_int = x.i; is_scalar = x.s; hev = x.he; lev = x.le;
    hdx = x.hx; ldx = x.lx; oen = x.oe; uen = x.ue; wr = x.w; wdata = x.wd;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 0; is_int = 0; is_scalar = 0; hev = '0; lev = '0;
    hdx = 0; ldx = 0; oen = 1; uen = 1; wr = 0; wdata = '0;
  endtask

  initial begin
    while (cyc < WATCHDOG_CYC && !done) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=%0d expected<%0d cycles", cyc, WATCHDOG_CYC);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    vec_t        x;
    valid = 0; is_int = 0; is_scalar = 0; hev = '0; lev = '0;
    hdx = 0; ldx = 0; oen = 1; uen = 1; wr = 0; wdata = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 reset", rdata, 32'h0);
    idle();
    rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R1 after release", rdata, 32'h0);

    for (int k = 0; k < 13; k++) begin
      apply(VECS[k]);
      check($sformatf("R%0d row %0d", VECS[k].req, k), rdata, VECS[k].exp);
    end

    // R4: an idle cycle with garbage on the event pins changes nothing
    x = '{4'd4, 1'b0,1'b1,1'b0, 8'hFF,8'hFF, 1'b1,1'b1,1'b0,1'b0,1'b0, 32'hFFFF_FFFF, 32'h0};
    apply(x);
    check("R4 idle hold", rdata, 32'h0024_0400);

    // R3: write wins over a simultaneous integer overflow
    x = '{4'd3, 1'b1,1'b1,1'b0, 8'h80,8'h80, 1'b0,1'b0,1'b1,1'b1,1'b1, 32'h0000_0200, 32'h0};
    apply(x);
    check("R3 write beats update", rdata, 32'h0000_0200);

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #(CLK_PERIOD/4);
    check("R1 async clear", rdata, 32'h0);
    idle();
    rst_n = 1'b1;

    // R9 R10 R11: random vectors against the requirement model
    exp = 32'h0;
    for (int k = 0; k < N_RAND; k++) begin
      x.req = 4'd9;
      x.v   = ($urandom_range(3) != 0);
      x.i   = ($urandom_range(3) == 0);
      x.s   = $urandom_range(1);
      x.he  = 8'($urandom);
      x.le  = 8'($urandom);
      x.hx  = ($urandom_range(3) == 0);
      x.lx  = ($urandom_range(3) == 0);
      x.oe  = $urandom_range(1);
      x.ue  = $urandom_range(1);
      x.w   = ($urandom_range(7) == 0);
      x.wd  = $urandom;
      x.exp = '0;
      exp = model(exp, x);
      apply(x);
      check($sformatf("R9 R10 R11 random step %0d", k), rdata, exp);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule